// File: doc/BRIEF.md
# Byte Arithmetic and Logic Unit with Packed-Decimal Correction

This unit does the data arithmetic of a small 8-bit processor. Each request carries an operation code, the working register byte, a second operand byte and the current processor status byte. The unit returns the new register byte and the new status byte. Carry is status bit 0, zero is bit 1, interrupt-mask is bit 2, decimal-mode is bit 3, break is bit 4, bit 5 is spare, overflow is bit 6 and sign is bit 7.

The operations are add and subtract with carry, compare, AND, OR, XOR, bit test, and single-bit shifts and rotates of the working byte. Add and subtract have a binary form and a packed-decimal form. Status bit 3 picks between the two. The decimal form adds 0x66 to the binary sum and uses the result to find which nibbles need a +6 fix.

Results are registered. A request strobe is accepted on any clock edge. Result, status and a one-cycle done pulse appear on the next edge. The result and status registers keep their values until the next request.

Top module: `alu8_core`

## Requirements
- R1: Add (op 0) forms the 16-bit sum A + B + C, where C is status bit 0. The result is the low byte of the sum. Carry is set when any bit above bit 7 is set. Overflow (bit 6) is bit 7 of (sum XOR A) AND (sum XOR B). Zero (bit 1) and sign (bit 7) come from the low byte of the sum.
- R2: When status bit 3 is set, add and subtract add 3 × ((((sum + 0x66) XOR A XOR B') >> 3) AND 0x22) to the binary sum. B' is the operand as fed to the adder. The result and carry come from the corrected value. Zero, sign and overflow still come from the uncorrected sum.
- R3: Subtract (op 1) uses B' = B XOR 0xFF. In decimal mode it also takes 0x66 from B', working modulo 2^16. It then follows the add path of R1/R2.
- R4: Compare (op 2) sets zero and sign from (A − B) mod 256. It sets carry when A ≥ B unsigned. The result byte equals A and overflow is unchanged.
- R5: AND (op 3), OR (op 4) and XOR (op 5) return the bitwise result. They set zero and sign from that result and leave carry and overflow unchanged.
- R6: Bit test (op 6) sets zero when A AND B is 0. It copies B bit 7 into sign and B bit 6 into overflow, and returns A as the result.
- R7: Shift left (op 7) moves A bit 7 into carry and fills bit 0 with 0. Shift right (op 8) moves A bit 0 into carry and fills bit 7 with 0. Both set zero and sign from the result.
- R8: Rotate left (op 9) moves the old carry into bit 0 and A bit 7 into carry. Rotate right (op 10) moves the old carry into bit 7 and A bit 0 into carry. Both set zero and sign from the result.
- R9: Status bits 2 to 5 always pass from input to output unchanged, for every operation.
- R10: `done` is high for exactly the cycle after each cycle in which `start` was high. `result` and `status_out` change only on such cycles.
- R11: While `rst` is held, `done`, `result` and `status_out` are all zero.
- R12: Op codes 11 to 15 return A as the result and the input status unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request strobe |
| op | input | 4 | Operation code |
| acc_in | input | 8 | Working register byte A |
| opnd_in | input | 8 | Second operand byte B |
| status_in | input | 8 | Current status byte |
| done | output | 1 | Result valid pulse |
| result | output | 8 | Registered result byte |
| status_out | output | 8 | Registered updated status |

## Verification
The hardest cases to reach are decimal subtracts where B XOR 0xFF is below 0x66. The 0x66 pre-adjust then wraps the operand past zero in 16 bits, and the later correction and carry depend on that high byte. The stimulus sets status bit 3 and uses operands of 0xA0 and above to force the wrap. It also covers decimal adds whose uncorrected sum differs in zero and sign from the corrected result, such as 0x99 + 0x01. Requests are issued back to back and also with gaps. This tests both the done pulse and that the output holds between requests.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    localparam int DW = 8;
    localparam int WW = 2 * DW;

    localparam int FLG_C = 0;
    localparam int FLG_Z = 1;
    localparam int FLG_D = 3;
    localparam int FLG_V = 6;
    localparam int FLG_N = 7;

    typedef enum logic [3:0] {
        OP_ADD = 4'd0,
        OP_SUB = 4'd1,
        OP_CMP = 4'd2,
        OP_AND = 4'd3,
        OP_OR  = 4'd4,
        OP_XOR = 4'd5,
        OP_BIT = 4'd6,
        OP_SHL = 4'd7,
        OP_SHR = 4'd8,
        OP_ROL = 4'd9,
        OP_ROR = 4'd10
    } alu_op_e;

    typedef struct packed {
        logic [DW-1:0] data;
        logic [DW-1:0] flags;
    } alu_out_t;

    function automatic logic [DW-1:0] upd_zn(logic [DW-1:0] f, logic [DW-1:0] v);
        logic [DW-1:0] r;
        r        = f;
        r[FLG_Z] = (v == '0);
        r[FLG_N] = v[DW-1];
        return r;
    endfunction

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub
    import alu8_pkg::*;
(
    input  logic          sub,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic [DW-1:0] flags_in,
    output alu_out_t      res
);
    localparam logic [WW-1:0] NIB_ADJ = WW'(16'h0066);
    localparam logic [WW-1:0] NIB_SEL = WW'(16'h0022);

    logic [WW-1:0] opnd;
    logic [WW-1:0] sum;
    logic [WW-1:0] fix;
    logic [WW-1:0] total;
    logic          dec;

    always_comb begin
        dec  = flags_in[FLG_D];
        opnd = {{DW{1'b0}}, (sub ? ~b : b)};
        if (sub && dec) opnd = opnd - NIB_ADJ;
        sum   = {{DW{1'b0}}, a} + opnd + {{(WW-1){1'b0}}, flags_in[FLG_C]};
        fix   = (((sum + NIB_ADJ) ^ {{DW{1'b0}}, a} ^ opnd) >> 3) & NIB_SEL;
        total = dec ? (sum + (fix << 1) + fix) : sum;

        res.data         = total[DW-1:0];
        res.flags        = upd_zn(flags_in, sum[DW-1:0]);
        res.flags[FLG_V] = ((sum[DW-1] ^ a[DW-1]) & (sum[DW-1] ^ opnd[DW-1]));
        res.flags[FLG_C] = |total[WW-1:DW];
    end
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
    import alu8_pkg::*;
(
    input  alu_op_e       op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic [DW-1:0] flags_in,
    output alu_out_t      res
);
    logic [DW-1:0] diff;

    always_comb begin
        diff      = a - b;
        res.data  = a;
        res.flags = flags_in;
        unique case (op)
            OP_CMP: begin
                res.flags        = upd_zn(flags_in, diff);
                res.flags[FLG_C] = (a >= b);
            end
            OP_AND: begin
                res.data  = a & b;
                res.flags = upd_zn(flags_in, a & b);
            end
            OP_OR: begin
                res.data  = a | b;
                res.flags = upd_zn(flags_in, a | b);
            end
            OP_XOR: begin
                res.data  = a ^ b;
                res.flags = upd_zn(flags_in, a ^ b);
            end
            OP_BIT: begin
                res.flags[FLG_Z] = ((a & b) == '0);
                res.flags[FLG_N] = b[DW-1];
                res.flags[FLG_V] = b[DW-2];
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/alu8_shift.sv
module alu8_shift
    import alu8_pkg::*;
(
    input  alu_op_e       op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] flags_in,
    output alu_out_t      res
);
    logic          cin;
    logic          left;
    logic          fill;
    logic [DW-1:0] val;

    always_comb begin
        cin  = flags_in[FLG_C];
        left = (op == OP_SHL) || (op == OP_ROL);
        fill = ((op == OP_ROL) || (op == OP_ROR)) ? cin : 1'b0;
        val  = left ? {a[DW-2:0], fill} : {fill, a[DW-1:1]};

        res.data         = val;
        res.flags        = upd_zn(flags_in, val);
        res.flags[FLG_C] = left ? a[DW-1] : a[0];
    end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [3:0]    op,
    input  logic [DW-1:0] acc_in,
    input  logic [DW-1:0] opnd_in,
    input  logic [DW-1:0] status_in,
    output logic          done,
    output logic [DW-1:0] result,
    output logic [DW-1:0] status_out
);
    alu_op_e  op_e;
    alu_out_t r_arith;
    alu_out_t r_logic;
    alu_out_t r_shift;
    alu_out_t r_sel;

    assign op_e = alu_op_e'(op);

    alu8_addsub u_arith (
        .sub      (op_e == OP_SUB),
        .a        (acc_in),
        .b        (opnd_in),
        .flags_in (status_in),
        .res      (r_arith)
    );

    alu8_logic u_logic (
        .op       (op_e),
        .a        (acc_in),
        .b        (opnd_in),
        .flags_in (status_in),
        .res      (r_logic)
    );

    alu8_shift u_shift (
        .op       (op_e),
        .a        (acc_in),
        .flags_in (status_in),
        .res      (r_shift)
    );

    always_comb begin
        unique case (op_e)
            OP_ADD, OP_SUB:                 r_sel = r_arith;
            OP_CMP, OP_AND, OP_OR, OP_XOR,
            OP_BIT:                         r_sel = r_logic;
            OP_SHL, OP_SHR, OP_ROL, OP_ROR: r_sel = r_shift;
            default: begin
                r_sel.data  = acc_in;
                r_sel.flags = status_in;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            done       <= 1'b0;
            result     <= '0;
            status_out <= '0;
        end else begin
            done <= start;
            if (start) begin
                result     <= r_sel.data;
                status_out <= r_sel.flags;
            end
        end
    end

    AST_DONE_AFTER_START: assert property (@(posedge clk) disable iff (rst)
        start |=> done);                                                   // R10
    AST_DONE_ONLY_AFTER_START: assert property (@(posedge clk) disable iff (rst)
        !start |=> !done);                                                 // R10
    AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!start && !$past(rst)) |=> ($stable(result) && $stable(status_out))); // R10
    AST_MID_BITS_PASS: assert property (@(posedge clk) disable iff (rst)
        start |=> (status_out[5:2] == $past(status_in[5:2])));             // R9
    AST_CMP_KEEPS_ACC: assert property (@(posedge clk) disable iff (rst)
        (start && op == 4'd2) |=> (result == $past(acc_in)));              // R4
    AST_BIT_COPIES: assert property (@(posedge clk) disable iff (rst)
        (start && op == 4'd6) |=> (status_out[7:6] == $past(opnd_in[7:6]) &&
                                   result == $past(acc_in)));              // R6
    AST_SHL_CARRY: assert property (@(posedge clk) disable iff (rst)
        (start && op == 4'd7) |=> (status_out[0] == $past(acc_in[7])));    // R7
endmodule

// File: tb/sim_alu8_core.sv
module sim_alu8_core;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [3:0] op = '0;
    logic [7:0] acc_in = '0;
    logic [7:0] opnd_in = '0;
    logic [7:0] status_in = '0;
    logic       done;
    logic [7:0] result;
    logic [7:0] status_out;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    logic [15:0] exp_q[$];
    string       tag_q[$];

    always #4 clk = ~clk;

    alu8_core u0 (
        .clk(clk), .rst(rst), .start(start), .op(op), .acc_in(acc_in),
        .opnd_in(opnd_in), .status_in(status_in), .done(done),
        .result(result), .status_out(status_out)
    );

    function automatic logic [15:0] model(input logic [3:0] o, input logic [7:0] a,
                                          input logic [7:0] b, input logic [7:0] s);
        int unsigned bb, sm, cr, tt;
        logic [7:0] r, f, t;
        r = a; f = s;
        case (o)
            4'd0, 4'd1: begin
                bb = (o == 4'd1) ? (32'(b) ^ 32'hFF) : 32'(b);
                if (o == 4'd1 && s[3]) bb = (bb - 32'h66) & 32'hFFFF;
                sm = (32'(a) + bb + 32'(s[0])) & 32'hFFFF;
                tt = sm;
                if (s[3]) begin
                    cr = (((sm + 32'h66) ^ 32'(a) ^ bb) >> 3) & 32'h22;
                    tt = (sm + 3 * cr) & 32'hFFFF;
                end
                r = tt[7:0];
                f[1] = (sm[7:0] == 8'h00); f[7] = sm[7];
                f[6] = ((sm ^ 32'(a)) & (sm ^ bb) & 32'h80) != 0;
                f[0] = (tt & 32'hFF00) != 0;
            end
            4'd2: begin
                t = a - b; f[1] = (t == 0); f[7] = t[7]; f[0] = (a >= b);
            end
            4'd3, 4'd4, 4'd5: begin
                r = (o == 4'd3) ? (a & b) : (o == 4'd4) ? (a | b) : (a ^ b);
                f[1] = (r == 0); f[7] = r[7];
            end
            4'd6: begin
                f[1] = ((a & b) == 0); f[7] = b[7]; f[6] = b[6];
            end
            4'd7, 4'd8, 4'd9, 4'd10: begin
                case (o)
                    4'd7:    begin r = a << 1;                f[0] = a[7]; end
                    4'd8:    begin r = a >> 1;                f[0] = a[0]; end
                    4'd9:    begin r = {a[6:0], s[0]};        f[0] = a[7]; end
                    default: begin r = {s[0], a[7:1]};        f[0] = a[0]; end
                endcase
                f[1] = (r == 0); f[7] = r[7];
            end
            default: ;
        endcase
        return {r, f};
    endfunction

    task automatic issue(input string tag, input logic [3:0] o, input logic [7:0] a,
                         input logic [7:0] b, input logic [7:0] s);
        @(negedge clk);
        start = 1'b1; op = o; acc_in = a; opnd_in = b; status_in = s;
        exp_q.push_back(model(o, a, b, s));
        tag_q.push_back(tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            start = 1'b0;
            op = 4'd3; acc_in = 8'h5A; opnd_in = 8'hFF; status_in = 8'hFF;
        end
    endtask

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: compare each done pulse with the head of the scoreboard
    logic [15:0] held;
    bit          seen_any = 1'b0;
    always @(posedge clk) begin
        #3;
        if (!rst) begin
            if (done) begin
                if (exp_q.size() == 0) begin
                    checks++; failures++;
                    $display("FAIL R10 actual=unexpected_done expected=no_done");
                end else begin
                    logic [15:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(t, {result, status_out}, e);
                    check({t, " R9"}, {8'h00, status_out & 8'h3C}, {8'h00, e[7:0] & 8'h3C});
                end
                held = {result, status_out};
                seen_any = 1'b1;
            end else if (seen_any) begin
                check("R10 hold", {result, status_out}, held);
            end
        end
    end

    initial begin
        fork
            begin
                #1_000_000;
                if (!finished) begin
                    checks++; failures++;
                    $display("FAIL watchdog actual=timeout expected=finish");
                    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
                    $finish;
                end
            end
        join_none

        repeat (3) @(negedge clk);
        check("R11 reset", {7'd0, done, result}, 16'h0000);
        check("R11 reset status", {8'h00, status_out}, 16'h0000);
        @(negedge clk); rst = 1'b0;

        // R1 binary add
        issue("R1 add overflow", 4'd0, 8'h50, 8'h50, 8'h00);
        issue("R1 add wrap", 4'd0, 8'hFF, 8'h01, 8'h00);
        issue("R1 add carry in", 4'd0, 8'h7F, 8'h00, 8'h01);
        // R2 decimal add
        issue("R2 dec add", 4'd0, 8'h15, 8'h27, 8'h08);
        issue("R2 dec add 99+1", 4'd0, 8'h99, 8'h01, 8'h08);
        issue("R2 dec add carry", 4'd0, 8'h58, 8'h46, 8'h09);
        idle(2);
        // R3 subtract
        issue("R3 bin sub", 4'd1, 8'h10, 8'h20, 8'h01);
        issue("R3 bin sub no borrow", 4'd1, 8'h40, 8'h40, 8'h01);
        issue("R3 dec sub", 4'd1, 8'h50, 8'h25, 8'h09);
        issue("R3 dec sub wrap", 4'd1, 8'h12, 8'hA0, 8'h08);
        issue("R3 dec sub borrow", 4'd1, 8'h00, 8'h01, 8'h09);
        // R4 compare
        issue("R4 cmp equal", 4'd2, 8'h33, 8'h33, 8'h40);
        issue("R4 cmp less", 4'd2, 8'h10, 8'h90, 8'h01);
        issue("R4 cmp greater", 4'd2, 8'hF0, 8'h01, 8'h00);
        idle(1);
        // R5 logic
        issue("R5 and zero", 4'd3, 8'hF0, 8'h0F, 8'h41);
        issue("R5 or", 4'd4, 8'h80, 8'h01, 8'h00);
        issue("R5 xor", 4'd5, 8'hFF, 8'hFF, 8'hC3);
        // R6 bit test
        issue("R6 bit", 4'd6, 8'h01, 8'hC0, 8'h01);
        issue("R6 bit nz", 4'd6, 8'h41, 8'h01, 8'hC0);
        // R7 shifts
        issue("R7 shl", 4'd7, 8'h81, 8'h00, 8'h00);
        issue("R7 shr", 4'd8, 8'h01, 8'h00, 8'h80);
        // R8 rotates
        issue("R8 rol", 4'd9, 8'h40, 8'h00, 8'h01);
        issue("R8 ror", 4'd10, 8'h01, 8'h00, 8'h01);
        issue("R8 ror no carry", 4'd10, 8'h02, 8'h00, 8'h00);
        idle(3);
        // R9 middle bits with all set
        issue("R9 add mid bits", 4'd0, 8'h01, 8'h01, 8'h3C);
        issue("R9 rol mid bits", 4'd9, 8'h80, 8'h00, 8'h3C);
        // R12 unused codes
        issue("R12 op11", 4'd11, 8'h6B, 8'h12, 8'hA5);
        issue("R12 op15", 4'd15, 8'h00, 8'hFF, 8'h5A);
        idle(4);

        // R10: every queued item must have been consumed
        check("R10 drained", 16'(exp_q.size()), 16'h0000);
        check("R10 done low when idle", {15'd0, done}, 16'h0000);

        // R11: reset mid-run clears outputs
        @(negedge clk); rst = 1'b1;
        @(negedge clk);
        check("R11 reset again", {7'd0, done, result}, 16'h0000);
        check("R11 reset again status", {8'h00, status_out}, 16'h0000);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule